// File: doc/BRIEF.md
# Programmable Colour Space Converter Matrix

This block converts one 12-bit three-component pixel per clock (RGB or YCbCr) into three new 12-bit components. Each output component is a signed fixed-point weighted sum of the three input components. Its weights have 12 fractional bits, so 4096 would stand for unity. A signed integer offset is added to that sum. The result is then multiplied by a gain of 1, 2 or 4 and limited to the 12-bit output range.

Twelve 13-bit coefficients, four per output channel, are loaded through a simple write port. The gain is chosen by a 2-bit mode input, which is sampled together with each pixel. Valid and horizontal sync travel through a delay line of the same length as the datapath, so they leave the block aligned with the pixel they came in with.

Top module: `csc_matrix`

## Requirements
- R1: Each output k equals clamp(((Ck0·in_c0 + Ck1·in_c1 + Ck2·in_c2) >> 12) + Ck3) scaled by the gain. The inputs are unsigned. The shift is arithmetic, so it rounds toward minus infinity.
- R2: Coefficients are 13-bit two's-complement. For example, 13'h1000 is −4096.
- R3: in_mode selects the gain, which is applied after the offset is added: 0 gives ×1, 1 gives ×2, 2 gives ×4, and 3 gives ×1.
- R4: A result below zero after the gain is output as 0.
- R5: A result above 4095 after the gain is output as 4095.
- R6: A pixel sampled at rising edge n appears on the outputs after edge n+2 (three register stages). out_valid and out_hsync show that pixel's in_valid and in_hsync in the same cycle.
- R7: cfg_addr = 4·k + t writes coefficient Ckt on the edge where cfg_we is high. t = 0, 1 and 2 weight in_c0, in_c1 and in_c2, and t = 3 is the offset. Writes to addresses 12 to 15 change nothing.
- R8: While rst_n is low at a clock edge, all coefficients, output components, out_valid and out_hsync are cleared to 0.
- R9: Pixels may arrive on consecutive clocks. Each pixel uses the mode and the coefficients that are in force at its sampling edge. A coefficient write on that same edge applies only from the next pixel onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_hsync | input | 1 | Horizontal sync travelling with the pixel |
| in_c0 | input | 12 | Input component 0 (R or Cr) |
| in_c1 | input | 12 | Input component 1 (G or Y) |
| in_c2 | input | 12 | Input component 2 (B or Cb) |
| in_mode | input | 2 | Gain select, sampled with the pixel |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 4 | Coefficient index, 4·channel + term |
| cfg_data | input | 13 | Coefficient value, signed |
| out_valid | output | 1 | Output pixel qualifier |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_c0 | output | 12 | Output component 0 |
| out_c1 | output | 12 | Output component 1 |
| out_c2 | output | 12 | Output component 2 |

## Verification
Three coefficient sets with different characters are loaded: a half-weight, a near-unity weight one LSB short of 4096, and a mixed negative and positive set with an offset. Pixels at zero, mid-range and full scale are then run under each gain.

A pixel of value 1 under the mixed set separates round-toward-minus-infinity from truncation. Full-scale inputs under ×4 force the upper clamp, and negative sums force the lower clamp. A coefficient of −4096 exposes any unsigned reading of the top coefficient bit.

Further pixels check the address map, ignored addresses, back-to-back pixels that meet a write on the same edge, and the latency and sideband alignment.

// File: rtl/csc_pkg.sv
// Shared constants and helpers for the colour space converter.
// Assumes a fixed three-stage pipeline; LAT_STAGES must match the datapath.
package csc_pkg;
    localparam int PIX_W      = 12;
    localparam int COEF_W     = 13;
    localparam int FRAC_W     = 12;
    localparam int N_CH       = 3;
    localparam int N_TERM     = 4;
    localparam int LAT_STAGES = 3;

    typedef enum logic [1:0] {
        GAIN_X1     = 2'd0,
        GAIN_X2     = 2'd1,
        GAIN_X4     = 2'd2,
        GAIN_X1_ALT = 2'd3
    } gain_e;

    // Map a gain selection to a left-shift amount; the spare code acts as x1.
    function automatic logic [1:0] gain_to_shift(input logic [1:0] sel);
        case (gain_e'(sel))
            GAIN_X2: return 2'd1;
            GAIN_X4: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/csc_coef_bank.sv
// Coefficient storage: N_CH*N_TERM signed words loaded one per write.
// Assumes the address is 4*channel + term. Addresses past the last entry are
// dropped. Contents clear to zero on reset.
module csc_coef_bank #(
    parameter int COEF_W = 13,
    parameter int N_CH   = 3,
    parameter int N_TERM = 4,
    localparam int N_ENT = N_CH * N_TERM,
    localparam int AW    = $clog2(N_ENT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [COEF_W-1:0]       wr_data,
    output logic [N_ENT*COEF_W-1:0] coef_flat
);
    logic [COEF_W-1:0] ent_q [N_ENT];

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        // Load this entry when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[e] <= '0;
            else if (wr_en && wr_addr == AW'(e))
                ent_q[e] <= wr_data;
        end
        assign coef_flat[e*COEF_W +: COEF_W] = ent_q[e];
    end

    // Writes outside the populated range leave storage untouched.
    assert_ignore_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) >= N_ENT) |=> $stable(coef_flat));

    // Reset clears every coefficient.
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (coef_flat == '0));
endmodule

// File: rtl/csc_channel.sv
// One output channel. It forms three signed products, sums them, rescales by
// 2^-FRAC_W with round toward minus infinity, adds the offset, applies the
// power-of-two gain and clamps to 0..2^PIX_W-1.
// Assumes unsigned pixel inputs. Three register stages, no stall.
module csc_channel #(
    parameter int PIX_W  = 12,
    parameter int COEF_W = 13,
    parameter int FRAC_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PIX_W-1:0]         pix_a,
    input  logic [PIX_W-1:0]         pix_b,
    input  logic [PIX_W-1:0]         pix_c,
    input  logic signed [COEF_W-1:0] k_a,
    input  logic signed [COEF_W-1:0] k_b,
    input  logic signed [COEF_W-1:0] k_c,
    input  logic signed [COEF_W-1:0] k_off,
    input  logic [1:0]               gain_sel,
    output logic [PIX_W-1:0]         res
);
    import csc_pkg::gain_to_shift;

    localparam int PROD_W  = COEF_W + PIX_W + 1;
    localparam int SUM_W   = PROD_W + 2;
    localparam int SCL_W   = SUM_W - FRAC_W;
    localparam int OFS_W   = ((SCL_W > COEF_W) ? SCL_W : COEF_W) + 1;
    localparam int GAIN_W  = OFS_W + 2;
    localparam int MAX_OUT = (1 << PIX_W) - 1;

    logic [PIX_W-1:0]         pix_v [3];
    logic signed [COEF_W-1:0] k_v   [3];
    logic signed [PROD_W-1:0] prod_q [3];
    logic signed [COEF_W-1:0] koff_q;
    logic [1:0]               sh1_q, sh2_q;
    logic signed [SUM_W-1:0]  sum_c;
    logic signed [SCL_W-1:0]  scl_c;
    logic signed [OFS_W-1:0]  ofs_c, ofs_q;
    logic signed [GAIN_W-1:0] gn_c;
    logic [PIX_W-1:0]         clip_c, res_q;

    // Gather the three operand pairs for the product loop.
    always_comb begin
        pix_v[0] = pix_a;  k_v[0] = k_a;
        pix_v[1] = pix_b;  k_v[1] = k_b;
        pix_v[2] = pix_c;  k_v[2] = k_c;
    end

    // Stage 1: register the products, the offset and the gain shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) prod_q[i] <= '0;
            koff_q <= '0;
            sh1_q  <= '0;
        end else begin
            for (int i = 0; i < 3; i++)
                prod_q[i] <= PROD_W'(k_v[i]) * PROD_W'($signed({1'b0, pix_v[i]}));
            koff_q <= k_off;
            sh1_q  <= gain_to_shift(gain_sel);
        end
    end

    // Sum with guard bits, drop the fraction (floor) and add the offset.
    always_comb begin
        sum_c = SUM_W'(prod_q[0]) + SUM_W'(prod_q[1]) + SUM_W'(prod_q[2]);
        scl_c = sum_c[SUM_W-1:FRAC_W];
        ofs_c = OFS_W'(scl_c) + OFS_W'(koff_q);
    end

    // Stage 2: register the offset-corrected sum and carry the shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= '0;
            sh2_q <= '0;
        end else begin
            ofs_q <= ofs_c;
            sh2_q <= sh1_q;
        end
    end

    // Apply the gain and clamp into the output range.
    always_comb begin
        gn_c = GAIN_W'(ofs_q) <<< sh2_q;
        if (gn_c[GAIN_W-1])
            clip_c = '0;
        else if (|gn_c[GAIN_W-2:PIX_W])
            clip_c = '1;
        else
            clip_c = gn_c[PIX_W-1:0];
    end

    // Stage 3: register the final component.
    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= clip_c;
    end

    assign res = res_q;

    // Negative sums leave as zero whatever the gain.
    assert_clamp_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_q < 0) |=> (res_q == '0));

    // Oversized sums leave as full scale.
    assert_clamp_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ofs_q) > MAX_OUT) |=> (int'(res_q) == MAX_OUT));

    // The x4 gain multiplies small in-range sums by exactly four.
    assert_gain_x4_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sh2_q == 2'd2 && ofs_q >= 0 && int'(ofs_q) <= MAX_OUT / 4)
        |=> (int'(res_q) == 4 * int'($past(ofs_q))));
endmodule

// File: rtl/csc_sideband_delay.sv
// Shift register that delays the sideband bits (valid, hsync) by DEPTH
// clocks so they match the datapath latency. Clears on reset.
module csc_sideband_delay #(
    parameter int W     = 2,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stg_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stg
        if (s == 0) begin : g_head
            // First stage takes the live sideband.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= d_in;
            end
        end else begin : g_body
            // Later stages follow the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign d_out = stg_q[DEPTH-1];
endmodule

// File: rtl/csc_matrix.sv
// Top of the colour space converter. It holds the coefficient bank, three
// channel datapaths and a sideband delay of matching length.
// Assumes one pixel per clock with no back-pressure. Mode and coefficients
// are taken at the pixel's sampling edge.
module csc_matrix #(
    parameter int PIX_W  = csc_pkg::PIX_W,
    parameter int COEF_W = csc_pkg::COEF_W,
    parameter int FRAC_W = csc_pkg::FRAC_W,
    localparam int N_CH   = csc_pkg::N_CH,
    localparam int N_TERM = csc_pkg::N_TERM,
    localparam int AW     = $clog2(N_CH * N_TERM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_hsync,
    input  logic [PIX_W-1:0]  in_c0,
    input  logic [PIX_W-1:0]  in_c1,
    input  logic [PIX_W-1:0]  in_c2,
    input  logic [1:0]        in_mode,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [COEF_W-1:0] cfg_data,
    output logic              out_valid,
    output logic              out_hsync,
    output logic [PIX_W-1:0]  out_c0,
    output logic [PIX_W-1:0]  out_c1,
    output logic [PIX_W-1:0]  out_c2
);
    logic [N_CH*N_TERM*COEF_W-1:0] coef_flat;
    logic [PIX_W-1:0]              res_v [N_CH];
    logic [1:0]                    side_out;

    csc_coef_bank #(.COEF_W(COEF_W), .N_CH(N_CH), .N_TERM(N_TERM)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_data),
        .coef_flat (coef_flat)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        localparam int BASE = k * N_TERM * COEF_W;
        csc_channel #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pix_a    (in_c0),
            .pix_b    (in_c1),
            .pix_c    (in_c2),
            .k_a      ($signed(coef_flat[BASE + 0*COEF_W +: COEF_W])),
            .k_b      ($signed(coef_flat[BASE + 1*COEF_W +: COEF_W])),
            .k_c      ($signed(coef_flat[BASE + 2*COEF_W +: COEF_W])),
            .k_off    ($signed(coef_flat[BASE + 3*COEF_W +: COEF_W])),
            .gain_sel (in_mode),
            .res      (res_v[k])
        );
    end

    csc_sideband_delay #(.W(2), .DEPTH(csc_pkg::LAT_STAGES)) u_side (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({in_hsync, in_valid}),
        .d_out (side_out)
    );

    assign out_valid = side_out[0];
    assign out_hsync = side_out[1];
    assign out_c0    = res_v[0];
    assign out_c1    = res_v[1];
    assign out_c2    = res_v[2];

    // Cycles since reset, kept only so the alignment check never looks before reset.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)               warm_q <= '0;
        else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
    end

    // Sideband leaves exactly three edges after it was sampled.
    assert_side_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3)
                              && out_hsync == $past(in_hsync, 3)));
endmodule

// File: tb/csc_matrix_bench.sv
module csc_matrix_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_hsync = 1'b0;
    logic [11:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic [1:0]  in_mode = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [12:0] cfg_data = '0;
    logic        out_valid, out_hsync;
    logic [11:0] out_c0, out_c1, out_c2;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    csc_matrix u_csc_matrix (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hsync(in_hsync),
        .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2), .in_mode(in_mode),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_hsync(out_hsync),
        .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
    );

    // Columns: c0, c1, c2, mode, expected out0, out1, out2 (coefficient set A).
    localparam int NV = 8;
    localparam int VEC [NV][7] = '{
        '{1000, 1000, 1000, 0,  500,  999,  350},
        '{4095, 4095, 4095, 0, 2047, 4094, 1123},
        '{3000, 2000,    0, 1, 3000, 3998,    0},
        '{3000, 3000, 1000, 2, 4095, 4095,    0},
        '{1001,    1, 2000, 3,  500,    0,  849},
        '{   0,    0,    0, 2,    0,    0,  400},
        '{   1,    0,    0, 1,    0,    0,  198},
        '{ 500,    2, 1000, 2, 1000,    4, 1900}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_data = 13'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One isolated pixel, checked after its third register stage.
    task automatic pix(input string tag, input int a, input int b, input int c,
                       input int m, input int e0, input int e1, input int e2);
        @(negedge clk);
        in_c0 = 12'(a); in_c1 = 12'(b); in_c2 = 12'(c); in_mode = 2'(m);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " out0"}, int'(out_c0), e0);
        chk({tag, " out1"}, int'(out_c1), e1);
        chk({tag, " out2"}, int'(out_c2), e2);
    endtask

    task automatic load_set_a();
        wr(0, 2048); wr(1, 0);    wr(2, 0);    wr(3, 0);
        wr(4, 0);    wr(5, 4095); wr(6, 0);    wr(7, 0);
        wr(8, 13'h1C00); wr(9, 0); wr(10, 2048); wr(11, 100);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state at the ports.
        chk("R8 reset valid", int'(out_valid), 0);
        chk("R8 reset hsync", int'(out_hsync), 0);
        chk("R8 reset out0", int'(out_c0), 0);
        @(negedge clk); rst_n = 1'b1;

        // R8: coefficients cleared, so any pixel gives zero.
        pix("R8 cleared coefs", 3000, 3000, 3000, 0, 0, 0, 0);

        load_set_a();
        // R1 R2 R3 R4 R5: table walk.
        for (int i = 0; i < NV; i++)
            pix($sformatf("R1 vec%0d", i), VEC[i][0], VEC[i][1], VEC[i][2],
                VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6]);

        // R6: latency and sideband alignment.
        @(negedge clk);
        in_c0 = 12'd1000; in_c1 = 12'd1000; in_c2 = 12'd1000; in_mode = 2'd0;
        in_valid = 1'b1; in_hsync = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_hsync = 1'b0;
        chk("R6 valid after edge n", int'(out_valid), 0);
        @(posedge clk); #1;
        chk("R6 valid after edge n+1", int'(out_valid), 0);
        @(posedge clk); #1;
        chk("R6 valid after edge n+2", int'(out_valid), 1);
        chk("R6 hsync after edge n+2", int'(out_hsync), 1);
        chk("R6 data after edge n+2", int'(out_c0), 500);
        @(posedge clk); #1;
        chk("R6 valid after edge n+3", int'(out_valid), 0);
        chk("R6 hsync after edge n+3", int'(out_hsync), 0);

        // R7: unused addresses change nothing.
        for (int a = 12; a < 16; a++) wr(a, 13'h0FFF);
        pix("R7 ignored addr", 1000, 1000, 1000, 0, 500, 999, 350);
        // R7: address map places offsets at 3 and 7.
        wr(3, 7); wr(7, 5);
        pix("R7 offset map", 1000, 1000, 1000, 0, 507, 1004, 350);
        wr(3, 0); wr(7, 0);

        // R2: -4096 must act as a negative weight.
        wr(8, 13'h1000);
        pix("R2 min coef", 100, 0, 4095, 0, 50, 0, 2047);

        // R9: back-to-back pixels with a write on the first pixel's edge.
        @(negedge clk);
        in_c0 = 12'd1000; in_c1 = 12'd0; in_c2 = 12'd0; in_mode = 2'd0;
        in_valid = 1'b1; cfg_we = 1'b1; cfg_addr = 4'd0; cfg_data = 13'd4095;
        @(negedge clk);
        cfg_we = 1'b0; in_mode = 2'd1;
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        chk("R9 first pixel valid", int'(out_valid), 1);
        chk("R9 first pixel old coef", int'(out_c0), 500);
        @(posedge clk); #1;
        chk("R9 second pixel valid", int'(out_valid), 1);
        chk("R9 second pixel new coef x2", int'(out_c0), 1998);

        // R8: a later reset clears the programmed coefficients.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        pix("R8 reset reclear", 1000, 1000, 1000, 0, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule